// File: doc/BRIEF.md
# Program Counter and Vectoring Unit

This unit holds the 15-bit program counter of a small 8-bit controller and chooses the next fetch address each cycle. A 3-bit command selects the action: hold, step to the next byte, jump to a full address, replace the upper 7 bits or the lower 8 bits on their own, call a subroutine, take an interrupt, or return. Calls and interrupts save a return address through a byte-wide stack port that faces RAM. Returns restore it through the same port. The stack pointer lives outside the unit: the unit raises increment and decrement strobes, and RAM is addressed by the external pointer.

A read wrapper sits between the program counter and program memory. It passes the memory byte through only when the location is present (programmed) and mapped. An absent location, an address beyond the mapped size, or the top address 0x7FFF all read as 0x00. A fetched 0x00 is the software-trap opcode, so the unit raises a trap request for it. A return issued while the stack is empty (pointer at 0x6F) jumps straight to 0x7FFF. The fetch there reads 0x00, so a stack underflow turns into a software trap.

The sequencer has four states:
- `SEQ_IDLE` accepts a command each cycle.
- `SEQ_PUSH_HI` writes the high return byte.
- `SEQ_POP_HI` reads the high byte.
- `SEQ_POP_LO` reads the low byte and loads the PC.

Its transitions are:
- IDLE→PUSH_HI on a call or interrupt.
- IDLE→POP_HI on a return with a non-empty stack.
- IDLE→IDLE on every other command, including an empty-stack return.
- PUSH_HI→IDLE.
- POP_HI→POP_LO.
- POP_LO→IDLE.

Top module: `pc_vector_unit`

## Requirements
- R1: While reset is asserted and in the first cycle after it, the PC is 0x0000. In that cycle busy, stack write, increment and decrement strobes are all low.
- R2: Command 1 (step) adds one to the PC in the next cycle. 0x7FFF steps to 0x0000.
- R3: Command 2 (jump) loads the 15-bit address input. Command 3 replaces PC bits 14:8 with byte input bits 6:0, leaving bits 7:0 unchanged. Command 4 replaces PC bits 7:0 with the byte input, leaving bits 14:8 unchanged.
- R4: Command 5 (call) writes the low byte of PC+1 with a decrement strobe in the accepting cycle. In the next cycle, with busy high, it writes {0, bits 14:8 of PC+1} with a decrement strobe. The PC then equals the address input.
- R5: Command 6 (interrupt) stores the current PC with the same two-write pattern as R4. The PC then becomes the vector 0x00FF.
- R6: Command 7 (return) with stack pointer ≠ 0x6F works as follows:
  - It raises increment in the accepting cycle.
  - Busy is high for the next two cycles. In the first of them, increment is high and the high byte is taken from stack read bits 6:0.
  - In the second, the low byte is taken from stack read data.
  - The PC then equals the popped address.
- R7: Command 7 with stack pointer = 0x6F causes no stack write and no pointer strobe, and keeps busy low. The PC is 0x7FFF in the next cycle.
- R8: The opcode output equals the memory data when the present input is 1, the PC is below the mapped size and the PC ≠ 0x7FFF. Otherwise it is 0x00.
- R9: The trap output is high exactly when the opcode output is 0x00 and busy is low.
- R10: Command 0 holds the PC. Every command presented while busy is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| op_i | input | 3 | Command: 0 hold, 1 step, 2 jump, 3 load high, 4 load low, 5 call, 6 interrupt, 7 return |
| addr_i | input | 15 | Jump or call target |
| byte_i | input | 8 | Byte for the half-loads |
| busy_o | output | 1 | Stack transfer in progress; fetch held off |
| pc_o | output | 15 | Program counter, the fetch address |
| pm_rdata_i | input | 8 | Raw program memory data at pc_o |
| pm_present_i | input | 1 | Location at pc_o holds programmed content |
| opcode_o | output | 8 | Fetched byte after the erased/unmapped filter |
| trap_o | output | 1 | Software trap request |
| sp_i | input | 8 | External stack pointer value |
| sp_inc_o | output | 1 | Increment the stack pointer at this edge |
| sp_dec_o | output | 1 | Decrement the stack pointer at this edge |
| stk_we_o | output | 1 | Write stk_wdata_o to RAM at sp_i |
| stk_wdata_o | output | 8 | Stack write byte |
| stk_rdata_i | input | 8 | RAM byte at sp_i |

## Verification
A trap request and the acceptance of an interrupt can fall in the same cycle. This happens when the current fetch reads 0x00 while the interrupt command is presented. The bench provokes it by clearing the present input at a mapped PC and issuing command 6 in that cycle. It then judges the cycle at the ports: trap_o must be high while the first stack write of the interrupt is already on the port. In the following busy cycle trap_o must fall even though the fetched byte is still 0x00. A second overlap, an empty-stack return landing on the trap address, is judged by reading trap_o in the cycle the PC reaches 0x7FFF.

// File: rtl/pcv_pkg.sv
package pcv_pkg;

    typedef enum logic [2:0] {
        OP_NOP     = 3'd0,
        OP_STEP    = 3'd1,
        OP_JUMP    = 3'd2,
        OP_LOAD_HI = 3'd3,
        OP_LOAD_LO = 3'd4,
        OP_CALL    = 3'd5,
        OP_INTR    = 3'd6,
        OP_RET     = 3'd7
    } pc_op_e;

    typedef enum logic [1:0] {
        SEQ_IDLE,
        SEQ_PUSH_HI,
        SEQ_POP_HI,
        SEQ_POP_LO
    } seq_state_e;

endpackage

// File: rtl/pcv_pm_read.sv
module pcv_pm_read #(
    parameter int ADDR_W    = 15,
    parameter int DATA_W    = 8,
    parameter int MAP_BYTES = 32768
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] raw_i,
    input  logic              present_i,
    output logic [DATA_W-1:0] data_o
);
    localparam logic [ADDR_W-1:0] TOP_ADDR = {ADDR_W{1'b1}};
    localparam logic [ADDR_W:0]   MAP_LIM  = MAP_BYTES[ADDR_W:0];

    logic in_map;

    generate
        if (MAP_BYTES < (2 ** ADDR_W)) begin : g_partial_map
            assign in_map = ({1'b0, addr_i} < MAP_LIM);
        end else begin : g_full_map
            assign in_map = 1'b1;
        end
    endgenerate

    always_comb begin
        if (present_i && in_map && (addr_i != TOP_ADDR)) begin
            data_o = raw_i;
        end else begin
            data_o = '0;
        end
    end

endmodule

// File: rtl/pcv_next.sv
module pcv_next
    import pcv_pkg::*;
#(
    parameter int PC_W = 15,
    parameter int LO_W = 8
) (
    input  pc_op_e            op_i,
    input  logic [PC_W-1:0]   pc_i,
    input  logic [PC_W-1:0]   addr_i,
    input  logic [LO_W-1:0]   byte_i,
    output logic              hit_o,
    output logic [PC_W-1:0]   next_o
);
    localparam int HI_W = PC_W - LO_W;

    always_comb begin
        hit_o  = 1'b1;
        next_o = pc_i;
        unique case (op_i)
            OP_STEP:    next_o = pc_i + PC_W'(1);
            OP_JUMP:    next_o = addr_i;
            OP_LOAD_HI: next_o = {byte_i[HI_W-1:0], pc_i[LO_W-1:0]};
            OP_LOAD_LO: next_o = {pc_i[PC_W-1:LO_W], byte_i};
            default:    hit_o  = 1'b0;
        endcase
    end

endmodule

// File: rtl/pcv_seq.sv
module pcv_seq
    import pcv_pkg::*;
#(
    parameter int              PC_W     = 15,
    parameter int              LO_W     = 8,
    parameter int              SP_W     = 8,
    parameter logic [SP_W-1:0] SP_EMPTY = 8'h6F,
    parameter logic [PC_W-1:0] VEC_ADDR = 15'h00FF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  pc_op_e            op_i,
    input  logic [PC_W-1:0]   pc_i,
    input  logic [PC_W-1:0]   target_i,
    input  logic [SP_W-1:0]   sp_i,
    input  logic [LO_W-1:0]   rdata_i,
    output logic              busy_o,
    output logic              stk_we_o,
    output logic [LO_W-1:0]   stk_wdata_o,
    output logic              sp_inc_o,
    output logic              sp_dec_o,
    output logic              ld_o,
    output logic [PC_W-1:0]   ld_addr_o
);
    localparam int              HI_W     = PC_W - LO_W;
    localparam int              PAD_W    = LO_W - HI_W;
    localparam logic [PC_W-1:0] TOP_ADDR = {PC_W{1'b1}};

    seq_state_e        state_q, state_d;
    logic [PC_W-1:0]   tgt_q;
    logic [LO_W-1:0]   ret_hi_q;
    logic [HI_W-1:0]   pop_hi_q;
    logic [PC_W-1:0]   ret_addr;
    logic              is_push, is_pop, is_underflow;

    assign is_push      = (op_i == OP_CALL) || (op_i == OP_INTR);
    assign is_pop       = (op_i == OP_RET) && (sp_i != SP_EMPTY);
    assign is_underflow = (op_i == OP_RET) && (sp_i == SP_EMPTY);
    assign ret_addr     = (op_i == OP_CALL) ? (pc_i + PC_W'(1)) : pc_i;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEQ_IDLE: begin
                if (is_push) begin
                    state_d = SEQ_PUSH_HI;
                end else if (is_pop) begin
                    state_d = SEQ_POP_HI;
                end
            end
            SEQ_PUSH_HI: state_d = SEQ_IDLE;
            SEQ_POP_HI:  state_d = SEQ_POP_LO;
            SEQ_POP_LO:  state_d = SEQ_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        busy_o      = 1'b0;
        stk_we_o    = 1'b0;
        stk_wdata_o = '0;
        sp_inc_o    = 1'b0;
        sp_dec_o    = 1'b0;
        ld_o        = 1'b0;
        ld_addr_o   = '0;
        unique case (state_q)
            SEQ_IDLE: begin
                if (is_push) begin
                    stk_we_o    = 1'b1;
                    stk_wdata_o = ret_addr[LO_W-1:0];
                    sp_dec_o    = 1'b1;
                end else if (is_pop) begin
                    sp_inc_o    = 1'b1;
                end else if (is_underflow) begin
                    ld_o        = 1'b1;
                    ld_addr_o   = TOP_ADDR;
                end
            end
            SEQ_PUSH_HI: begin
                busy_o      = 1'b1;
                stk_we_o    = 1'b1;
                stk_wdata_o = ret_hi_q;
                sp_dec_o    = 1'b1;
                ld_o        = 1'b1;
                ld_addr_o   = tgt_q;
            end
            SEQ_POP_HI: begin
                busy_o      = 1'b1;
                sp_inc_o    = 1'b1;
            end
            SEQ_POP_LO: begin
                busy_o      = 1'b1;
                ld_o        = 1'b1;
                ld_addr_o   = {pop_hi_q, rdata_i};
            end
        endcase
    end

    // Transfer data registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tgt_q    <= '0;
            ret_hi_q <= '0;
            pop_hi_q <= '0;
        end else begin
            if ((state_q == SEQ_IDLE) && is_push) begin
                tgt_q    <= (op_i == OP_CALL) ? target_i : VEC_ADDR;
                ret_hi_q <= {{PAD_W{1'b0}}, ret_addr[PC_W-1:LO_W]};
            end
            if (state_q == SEQ_POP_HI) begin
                pop_hi_q <= rdata_i[HI_W-1:0];
            end
        end
    end

    // R4 / R5: an accepted push is followed by the second write while busy
    assert_push_pair_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (stk_we_o && !busy_o) |=> (stk_we_o && busy_o && sp_dec_o));

    // R6: an accepted pop is followed by a second increment while busy
    assert_pop_pair_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (sp_inc_o && !busy_o) |=> (sp_inc_o && busy_o));

    // R6: the low-byte cycle ends the transfer
    assert_pop_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (sp_inc_o && busy_o) |=> (busy_o && !sp_inc_o && !stk_we_o));

endmodule

// File: rtl/pc_vector_unit.sv
module pc_vector_unit
    import pcv_pkg::*;
#(
    parameter int              PC_W      = 15,
    parameter int              LO_W      = 8,
    parameter int              SP_W      = 8,
    parameter logic [SP_W-1:0] SP_EMPTY  = 8'h6F,
    parameter logic [PC_W-1:0] VEC_ADDR  = 15'h00FF,
    parameter int              MAP_BYTES = 32768
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        op_i,
    input  logic [PC_W-1:0]   addr_i,
    input  logic [LO_W-1:0]   byte_i,
    output logic              busy_o,
    output logic [PC_W-1:0]   pc_o,
    input  logic [LO_W-1:0]   pm_rdata_i,
    input  logic              pm_present_i,
    output logic [LO_W-1:0]   opcode_o,
    output logic              trap_o,
    input  logic [SP_W-1:0]   sp_i,
    output logic              sp_inc_o,
    output logic              sp_dec_o,
    output logic              stk_we_o,
    output logic [LO_W-1:0]   stk_wdata_o,
    input  logic [LO_W-1:0]   stk_rdata_i
);
    localparam logic [PC_W-1:0] TOP_ADDR = {PC_W{1'b1}};

    pc_op_e            op;
    logic [PC_W-1:0]   pc_q;
    logic              seq_ld;
    logic [PC_W-1:0]   seq_ld_addr;
    logic              simple_hit;
    logic [PC_W-1:0]   simple_next;

    assign op = pc_op_e'(op_i);

    pcv_next #(
        .PC_W (PC_W),
        .LO_W (LO_W)
    ) u_next (
        .op_i   (op),
        .pc_i   (pc_q),
        .addr_i (addr_i),
        .byte_i (byte_i),
        .hit_o  (simple_hit),
        .next_o (simple_next)
    );

    pcv_seq #(
        .PC_W     (PC_W),
        .LO_W     (LO_W),
        .SP_W     (SP_W),
        .SP_EMPTY (SP_EMPTY),
        .VEC_ADDR (VEC_ADDR)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .op_i        (op),
        .pc_i        (pc_q),
        .target_i    (addr_i),
        .sp_i        (sp_i),
        .rdata_i     (stk_rdata_i),
        .busy_o      (busy_o),
        .stk_we_o    (stk_we_o),
        .stk_wdata_o (stk_wdata_o),
        .sp_inc_o    (sp_inc_o),
        .sp_dec_o    (sp_dec_o),
        .ld_o        (seq_ld),
        .ld_addr_o   (seq_ld_addr)
    );

    pcv_pm_read #(
        .ADDR_W    (PC_W),
        .DATA_W    (LO_W),
        .MAP_BYTES (MAP_BYTES)
    ) u_pm_read (
        .addr_i    (pc_q),
        .raw_i     (pm_rdata_i),
        .present_i (pm_present_i),
        .data_o    (opcode_o)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q <= '0;
        end else if (seq_ld) begin
            pc_q <= seq_ld_addr;
        end else if (!busy_o && simple_hit) begin
            pc_q <= simple_next;
        end
    end

    assign pc_o   = pc_q;
    assign trap_o = (opcode_o == '0) && !busy_o;

    assert_reset_pc_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (pc_q == '0 && !busy_o));

    assert_step_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && op == OP_STEP && pc_q == TOP_ADDR) |=> (pc_q == '0));

    assert_vector_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(!busy_o && op == OP_INTR)) |=> (pc_q == VEC_ADDR));

    assert_underflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && op == OP_RET && sp_i == SP_EMPTY) |=> (pc_q == TOP_ADDR && !busy_o));

    assert_top_trap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_q == TOP_ADDR && !busy_o) |-> trap_o);

    assert_busy_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !seq_ld) |=> $stable(pc_q));

endmodule

// File: tb/pc_vector_unit_tb_top.sv
module pc_vector_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  op_i = 3'd0;
    logic [14:0] addr_i = '0;
    logic [7:0]  byte_i = '0;
    logic        busy_o;
    logic [14:0] pc_o;
    logic [7:0]  pm_rdata_i;
    logic        pm_present_i = 1'b1;
    logic [7:0]  opcode_o;
    logic        trap_o;
    logic [7:0]  sp = 8'h6F;
    logic        sp_inc_o, sp_dec_o, stk_we_o;
    logic [7:0]  stk_wdata_o;
    logic [7:0]  stk_rdata_i;
    logic [7:0]  ram [256];

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    assign pm_rdata_i  = pc_o[7:0] ^ 8'h5A;
    assign stk_rdata_i = ram[sp];

    always @(posedge clk) begin
        if (!rst_n) begin
            sp <= 8'h6F;
        end else begin
            if (stk_we_o) ram[sp] <= stk_wdata_o;
            if (sp_dec_o) sp <= sp - 8'd1;
            else if (sp_inc_o) sp <= sp + 8'd1;
        end
    end

    pc_vector_unit #(
        .MAP_BYTES (16384)
    ) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .op_i         (op_i),
        .addr_i       (addr_i),
        .byte_i       (byte_i),
        .busy_o       (busy_o),
        .pc_o         (pc_o),
        .pm_rdata_i   (pm_rdata_i),
        .pm_present_i (pm_present_i),
        .opcode_o     (opcode_o),
        .trap_o       (trap_o),
        .sp_i         (sp),
        .sp_inc_o     (sp_inc_o),
        .sp_dec_o     (sp_dec_o),
        .stk_we_o     (stk_we_o),
        .stk_wdata_o  (stk_wdata_o),
        .stk_rdata_i  (stk_rdata_i)
    );

    // {command, argument, expected PC after one edge}
    localparam logic [32:0] VECS [10] = '{
        {3'd1, 15'h0000, 15'h0001},
        {3'd1, 15'h0000, 15'h0002},
        {3'd2, 15'h1234, 15'h1234},
        {3'd4, 15'h00AB, 15'h12AB},
        {3'd3, 15'h00FF, 15'h7FAB},
        {3'd0, 15'h0000, 15'h7FAB},
        {3'd2, 15'h7FFF, 15'h7FFF},
        {3'd1, 15'h0000, 15'h0000},
        {3'd3, 15'h0005, 15'h0500},
        {3'd1, 15'h0000, 15'h0501}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic drive(input logic [2:0] op, input logic [14:0] a);
        op_i   = op;
        addr_i = a;
        byte_i = a[7:0];
    endtask

    function automatic string tag_of(input logic [2:0] op);
        case (op)
            3'd0:    return "R10 hold";
            3'd1:    return "R2 step";
            default: return "R3 load";
        endcase
    endfunction

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 pc", 32'(pc_o), 32'h0);
        check("R1 busy", 32'(busy_o), 32'h0);
        check("R1 strobes", 32'({stk_we_o, sp_inc_o, sp_dec_o}), 32'h0);

        for (int i = 0; i < 10; i++) begin
            drive(VECS[i][32:30], VECS[i][29:15]);
            tick();
            check(tag_of(VECS[i][32:30]), 32'(pc_o), 32'(VECS[i][14:0]));
        end

        // R8 opcode pass-through at a mapped, present address 0x0501
        drive(3'd0, '0);
        check("R8 mapped data", 32'(opcode_o), 32'h5B);
        check("R9 no trap", 32'(trap_o), 32'h0);

        // R4 call to 0x2000 from 0x0501, return address 0x0502
        drive(3'd5, 15'h2000);
        #1;
        check("R4 first write", 32'({stk_we_o, sp_dec_o, busy_o}), 32'b110);
        check("R4 low byte", 32'(stk_wdata_o), 32'h02);
        tick();
        drive(3'd2, 15'h3333);   // must be ignored while busy
        #1;
        check("R4 second write", 32'({stk_we_o, sp_dec_o, busy_o}), 32'b111);
        check("R4 high byte", 32'(stk_wdata_o), 32'h05);
        tick();
        drive(3'd0, '0);
        check("R4 target / R10 busy ignore", 32'(pc_o), 32'h2000);
        check("R4 busy clear", 32'(busy_o), 32'h0);
        check("R4 stack bytes", 32'({ram[8'h6F], ram[8'h6E], sp}), 32'h02056D);

        // R5 interrupt accepted in the same cycle as a trap request
        pm_present_i = 1'b0;
        #1;
        check("R8 absent reads zero", 32'(opcode_o), 32'h0);
        drive(3'd6, '0);
        #1;
        check("R9 trap with intr accept", 32'({trap_o, stk_we_o}), 32'b11);
        check("R5 low byte", 32'(stk_wdata_o), 32'h00);
        tick();
        drive(3'd0, '0);
        #1;
        check("R9 trap gated by busy", 32'(trap_o), 32'h0);
        check("R5 high byte", 32'(stk_wdata_o), 32'h20);
        tick();
        check("R5 vector", 32'(pc_o), 32'h00FF);
        pm_present_i = 1'b1;
        #1;
        check("R8 vector fetch", 32'(opcode_o), 32'hA5);

        // R6 return to 0x2000
        drive(3'd7, '0);
        #1;
        check("R6 accept inc", 32'({sp_inc_o, busy_o, stk_we_o}), 32'b100);
        tick();
        drive(3'd0, '0);
        check("R6 first busy", 32'({sp_inc_o, busy_o}), 32'b11);
        tick();
        check("R6 second busy", 32'({sp_inc_o, busy_o}), 32'b01);
        tick();
        check("R6 popped pc", 32'(pc_o), 32'h2000);
        check("R6 busy clear", 32'(busy_o), 32'h0);

        // R6 return to 0x0502
        drive(3'd7, '0);
        tick();
        drive(3'd0, '0);
        tick();
        tick();
        check("R6 second return", 32'({pc_o, sp}), 32'({15'h0502, 8'h6F}));

        // R7 empty-stack return
        drive(3'd7, '0);
        #1;
        check("R7 no traffic", 32'({stk_we_o, sp_inc_o, sp_dec_o, busy_o}), 32'h0);
        tick();
        drive(3'd0, '0);
        check("R7 top address", 32'(pc_o), 32'h7FFF);
        check("R7 busy low", 32'(busy_o), 32'h0);
        check("R8 top reads zero", 32'(opcode_o), 32'h0);
        check("R9 trap at top", 32'(trap_o), 32'h1);

        // R8 mapped-size boundary (mapped size 0x4000 here)
        drive(3'd2, 15'h4000);
        tick();
        check("R8 unmapped", 32'(opcode_o), 32'h0);
        drive(3'd2, 15'h3FFF);
        tick();
        drive(3'd0, '0);
        check("R8 last mapped", 32'(opcode_o), 32'hA5);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule